// File: doc/BRIEF.md
# Host Bus Acquisition Controller

This block lets an on-chip DMA engine take over a shared host system bus from whatever master currently holds it. When the DMA side asks for the bus, the controller raises a hold request toward the host. It then watches two asynchronous host inputs, a hold grant and a bus-busy flag, through multi-flop synchronizers. Once the grant is present and the bus is not busy, it steps through two fixed idle cycles. It asserts bus ownership in the second of them, then keeps the read and write strobes released for one more clock before driving them to their inactive level.

While it owns the bus, the controller gives the data-direction control its value: low for a DMA read, high for a DMA write. It also masks the host's chip-select input so that the embedded slave port cannot be addressed. When the DMA request goes away, it gives the bus back in a fixed order. The strobes are released first, then ownership and the direction control, and the hold request is dropped last. Tri-state outputs are modelled as a value plus a separate enable. Address generation and the data transfer itself belong to neighbouring blocks.

All signals are sampled on the rising edge of `clk`. The reset input `rstN` is asynchronous and active low.

Top module: `bus_acquire_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `holdReq` is 0, `ownN` is 1, `strobeOe` is 0 and `dirOe` is 0.
- R2: With the block idle, `holdReq` becomes 1 at the first rising edge that samples `dmaReq` high.
- R3: `ownN` stays 1 for as long as the synchronized `busBusy` is 1, even if `holdAck` is 1. Ownership is taken only when the synchronized `holdAck` is 1 and the synchronized `busBusy` is 0.
- R4: Take a case where `holdReq` is 1, `busBusy` has been 0 for a long time, and `holdAck` rises before an edge. `ownN` then falls (0 means owned) exactly at the fourth rising edge counting that edge as the first: two synchronizer stages, one grant-check edge and one idle edge.
- R5: `dirOe` becomes 1 at the same edge at which `ownN` falls. `dirOut` is then 0 if `dmaRead` was 1 when the request was accepted, and 1 otherwise.
- R6: `strobeOe` stays 0 for two edges after `ownN` falls and becomes 1 at the second edge after the fall. From then on `rdStrobeN` and `wrStrobeN` are both 1.
- R7: `hostSelN` is 1 whenever `ownN` is 0, whatever the value of `chipSelN`. It equals `chipSelN` while `ownN` is 1.
- R8: When `dmaReq` is sampled low while the bus is owned, the release happens one edge per step in this order. First `strobeOe` goes to 0 while `ownN` stays 0. At the next edge `ownN` goes to 1 and `dirOe` to 0 while `holdReq` stays 1. At the edge after that, `holdReq` goes to 0.
- R9: If `dmaReq` is sampled low while the controller is still waiting for the grant, `holdReq` goes to 0 at the second edge after that sample, and `ownN` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dmaReq | input | 1 | DMA engine wants the bus (level) |
| dmaRead | input | 1 | 1 = DMA read, 0 = DMA write; captured when the request is accepted |
| busBusy | input | 1 | Asynchronous: another master still occupies the bus (active high) |
| holdAck | input | 1 | Asynchronous: host grants the hold request (active high) |
| chipSelN | input | 1 | Host chip-select for the slave port, active low |
| holdReq | output | 1 | Hold request to the host, active high |
| ownN | output | 1 | Bus ownership indication, active low |
| dirOut | output | 1 | Data-direction value, 0 for read, 1 for write |
| dirOe | output | 1 | Drive enable for `dirOut` |
| rdStrobeN | output | 1 | Read strobe value, meaningful only when `strobeOe` is 1 |
| wrStrobeN | output | 1 | Write strobe value, meaningful only when `strobeOe` is 1 |
| strobeOe | output | 1 | Drive enable for both strobes |
| hostSelN | output | 1 | Chip-select passed on to the slave port, masked while owning |

## Verification
The assertions assume that the host raises `holdAck` only while `holdReq` is high. They also assume that `busBusy` and `holdAck` change at most once per clock, so that the synchronizers settle in their nominal number of stages. The timing claim tying the fall of `ownN` to the synchronized grant depends on both. The bench drives every input just after a falling edge, raises the grant only after it has seen the hold request, and withdraws the grant only after the controller has returned to idle. This keeps the stimulus inside those assumptions.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_GRANT,
    ST_I1,
    ST_I2,
    ST_TX,
    ST_OWNED,
    ST_REL_STB,
    ST_REL_OWN
  } acqState_t;

  // Strobes from the sequencer to the output stage, decoded for the next state
  typedef struct packed {
    logic holdReq;
    logic own;
    logic dirDrive;
    logic strobeDrive;
    logic latchDir;
  } acqCtrl_t;

endpackage

// File: rtl/acq_sync.sv
`timescale 1ns/1ps
module acq_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/acq_ctrl.sv
`timescale 1ns/1ps
module acq_ctrl
  import acq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dmaReq,
  input  logic     ackSync,
  input  logic     busySync,
  output acqCtrl_t ctrlNext
);

  acqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:       if (dmaReq) nextState = ST_REQ;
      ST_REQ:        nextState = ST_WAIT_GRANT;
      ST_WAIT_GRANT: begin
        if (!dmaReq)                    nextState = ST_REL_OWN;
        else if (ackSync && !busySync)  nextState = ST_I1;
      end
      ST_I1:         nextState = ST_I2;
      ST_I2:         nextState = ST_TX;
      ST_TX:         nextState = ST_OWNED;
      ST_OWNED:      if (!dmaReq) nextState = ST_REL_STB;
      ST_REL_STB:    nextState = ST_REL_OWN;
      ST_REL_OWN:    nextState = ST_IDLE;
      default:       nextState = ST_IDLE;
    endcase
  end

  // Decode on the next state so registered outputs line up with the state
  always_comb begin
    ctrlNext.holdReq     = (nextState != ST_IDLE);
    ctrlNext.own         = (nextState == ST_I2) || (nextState == ST_TX) ||
                           (nextState == ST_OWNED) || (nextState == ST_REL_STB);
    ctrlNext.dirDrive    = ctrlNext.own;
    ctrlNext.strobeDrive = (nextState == ST_OWNED);
    ctrlNext.latchDir    = (state == ST_IDLE) && (nextState == ST_REQ);
  end

  // Ownership may only be reached by passing through a grant wait first
  AST_I1_FROM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_I1) |-> ($past(state) == ST_WAIT_GRANT) && $past(ackSync) && !$past(busySync)); // R3

endmodule

// File: rtl/acq_datapath.sv
`timescale 1ns/1ps
module acq_datapath
  import acq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  acqCtrl_t ctrlNext,
  input  logic     dmaRead,
  input  logic     chipSelN,
  output logic     holdReq,
  output logic     ownN,
  output logic     dirOut,
  output logic     dirOe,
  output logic     rdStrobeN,
  output logic     wrStrobeN,
  output logic     strobeOe,
  output logic     hostSelN
);

  logic holdReqQ, ownQ, dirOeQ, strobeOeQ, dirReadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReqQ  <= 1'b0;
      ownQ      <= 1'b0;
      dirOeQ    <= 1'b0;
      strobeOeQ <= 1'b0;
      dirReadQ  <= 1'b0;
    end else begin
      holdReqQ  <= ctrlNext.holdReq;
      ownQ      <= ctrlNext.own;
      dirOeQ    <= ctrlNext.dirDrive;
      strobeOeQ <= ctrlNext.strobeDrive;
      if (ctrlNext.latchDir) dirReadQ <= dmaRead;
    end
  end

  assign holdReq   = holdReqQ;
  assign ownN      = ~ownQ;
  assign dirOut    = ~dirReadQ;
  assign dirOe     = dirOeQ;
  assign strobeOe  = strobeOeQ;
  assign rdStrobeN = strobeOeQ;
  assign wrStrobeN = strobeOeQ;
  assign hostSelN  = ownQ | chipSelN;

  AST_OWN_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ownN |-> holdReq); // R8

  AST_DIR_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    dirOe |-> !ownN); // R5

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeOe) |-> (!ownN && $past(!ownN) && $past(!ownN, 2))); // R6

  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownN) |-> (!strobeOe && !$past(strobeOe) && holdReq)); // R8

  AST_HOLD_DROP_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdReq) |-> (ownN && $past(ownN))); // R9

endmodule

// File: rtl/bus_acquire_ctrl.sv
`timescale 1ns/1ps
module bus_acquire_ctrl
  import acq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dmaReq,
  input  logic dmaRead,
  input  logic busBusy,
  input  logic holdAck,
  input  logic chipSelN,
  output logic holdReq,
  output logic ownN,
  output logic dirOut,
  output logic dirOe,
  output logic rdStrobeN,
  output logic wrStrobeN,
  output logic strobeOe,
  output logic hostSelN
);

  localparam int SYNC_W = 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = 2'b10; // busy assumed, no grant

  logic [SYNC_W-1:0] syncQ;
  logic              busySync, ackSync;
  acqCtrl_t          ctrlNext;

  acq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({busBusy, holdAck}),
    .syncOut (syncQ)
  );

  assign busySync = syncQ[1];
  assign ackSync  = syncQ[0];

  acq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .dmaReq   (dmaReq),
    .ackSync  (ackSync),
    .busySync (busySync),
    .ctrlNext (ctrlNext)
  );

  acq_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlNext  (ctrlNext),
    .dmaRead   (dmaRead),
    .chipSelN  (chipSelN),
    .holdReq   (holdReq),
    .ownN      (ownN),
    .dirOut    (dirOut),
    .dirOe     (dirOe),
    .rdStrobeN (rdStrobeN),
    .wrStrobeN (wrStrobeN),
    .strobeOe  (strobeOe),
    .hostSelN  (hostSelN)
  );

  // Ownership is taken two edges after a clean synchronized grant was seen
  AST_OWN_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ownN) |-> ($past(ackSync, 2) && !$past(busySync, 2))); // R4

endmodule

// File: tb/sim_bus_acquire_ctrl.sv
`timescale 1ns/1ps
module sim_bus_acquire_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaReq = 1'b0, dmaRead = 1'b0, busBusy = 1'b0, holdAck = 1'b0, chipSelN = 1'b1;
  logic holdReq, ownN, dirOut, dirOe, rdStrobeN, wrStrobeN, strobeOe, hostSelN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_acquire_ctrl u0 (
    .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .dmaRead(dmaRead),
    .busBusy(busBusy), .holdAck(holdAck), .chipSelN(chipSelN),
    .holdReq(holdReq), .ownN(ownN), .dirOut(dirOut), .dirOe(dirOe),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .strobeOe(strobeOe),
    .hostSelN(hostSelN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    check(act === exp, tag, int'(act), int'(exp));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Request the bus, wait for hold, grant, and follow R4/R5/R6 timing
  task automatic acquire(input logic rd);
    dmaReq = 1'b1;
    dmaRead = rd;
    step();
    chk("R2 holdReq after request", holdReq, 1'b1);
    dmaRead = ~rd;  // must be ignored once captured
    holdAck = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 ownN before fourth edge", ownN, 1'b1);
    end
    step();
    chk("R4 ownN at fourth edge", ownN, 1'b0);
    chk("R5 dirOe with ownership", dirOe, 1'b1);
    chk("R5 dirOut value", dirOut, ~rd);
    chk("R6 strobes released in idle", strobeOe, 1'b0);
    step();
    chk("R6 strobes released one more clock", strobeOe, 1'b0);
    step();
    chk("R6 strobes driven", strobeOe, 1'b1);
    chk("R6 read strobe high", rdStrobeN, 1'b1);
    chk("R6 write strobe high", wrStrobeN, 1'b1);
  endtask

  task automatic releaseBus();
    dmaReq = 1'b0;
    step();
    chk("R8 strobes off first", strobeOe, 1'b0);
    chk("R8 ownership kept", ownN, 1'b0);
    step();
    chk("R8 ownership dropped", ownN, 1'b1);
    chk("R8 dirOe dropped", dirOe, 1'b0);
    chk("R8 hold kept", holdReq, 1'b1);
    step();
    chk("R8 hold dropped last", holdReq, 1'b0);
    holdAck = 1'b0;
    for (int i = 0; i < 4; i++) step();
  endtask

  task automatic testReset();
    chk("R1 holdReq in reset", holdReq, 1'b0);
    chk("R1 ownN in reset", ownN, 1'b1);
    rstN = 1'b1;
    step();
    chk("R1 holdReq after reset", holdReq, 1'b0);
    chk("R1 ownN after reset", ownN, 1'b1);
    chk("R1 strobeOe after reset", strobeOe, 1'b0);
    chk("R1 dirOe after reset", dirOe, 1'b0);
  endtask

  task automatic testReadWithSelect();
    chipSelN = 1'b0;
    step();
    chk("R7 select passes when idle", hostSelN, 1'b0);
    acquire(1'b1);
    chk("R7 select masked while owning", hostSelN, 1'b1);
    chipSelN = 1'b1;
    step();
    chk("R7 select masked while owning high", hostSelN, 1'b1);
    chipSelN = 1'b0;
    releaseBus();
    chk("R7 select passes after release", hostSelN, 1'b0);
    chipSelN = 1'b1;
  endtask

  task automatic testWrite();
    acquire(1'b0);
    releaseBus();
  endtask

  task automatic testBusy();
    busBusy = 1'b1;
    for (int i = 0; i < 4; i++) step();
    dmaReq = 1'b1;
    dmaRead = 1'b1;
    step();
    holdAck = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      chk("R3 no ownership while busy", ownN, 1'b1);
    end
    busBusy = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 ownN before busy clears through sync", ownN, 1'b1);
    end
    step();
    chk("R3 ownership once not busy", ownN, 1'b0);
    for (int i = 0; i < 2; i++) step();
    releaseBus();
  endtask

  task automatic testAbort();
    dmaReq = 1'b1;
    step();
    for (int i = 0; i < 3; i++) step();
    chk("R9 still holding while waiting", holdReq, 1'b1);
    dmaReq = 1'b0;
    step();
    chk("R9 hold kept one edge", holdReq, 1'b1);
    chk("R9 no ownership", ownN, 1'b1);
    step();
    chk("R9 hold dropped", holdReq, 1'b0);
    chk("R9 still no ownership", ownN, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testReadWithSelect();
    testWrite();
    testBusy();
    testAbort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule